// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

The tracker sits between a processor request port and a cache controller's request queue. It keeps a record of every memory request in flight, keyed by cache-line address. Read-class requests and write-class requests are held in two separate small associative tables. Each table entry has a valid bit, a line address and the cycle stamp at which the request was accepted.

Each incoming request is screened, and the tracker answers one cycle later with a single result code:
- **Illegal**: the request is malformed.
- **Aliased**: the request hits a line that is already outstanding in either table.
- **Full**: the number of outstanding requests has reached the configured ceiling.
- **Issued**: the request is accepted. The tracker stamps it and sends a translated coherence request downstream.

A completion names a table and a line. It frees the matching entry and reports how many cycles the request was outstanding. An age watchdog compares every live entry against a threshold and latches a possible-deadlock flag. Aliasing stalls are sorted into four saturating counters by the kind of the blocked request and the table it collided with.

Top module: `outstanding_tracker`

## Requirements
- R1: Kinds 2 (store), 3 (rmw read), 4 (rmw write), 5 (linked load), 6 (conditional store), 7 (locked rmw read) and 8 (locked rmw write) enter the write table. Kinds 0 (load) and 1 (fetch) enter the read table. A completion only retires an entry in the table selected by `cpl_is_write` (1 = write table).
- R2: A request whose line (address bits above the line offset) is held by either table is answered with code 1 (aliased). It is not inserted, and the outstanding count is unchanged.
- R3: A legal request that does not alias, arriving while the outstanding count is at least MAX_OUT, is answered with code 2 (full) and not inserted. Any other legal request is answered with code 0 (issued) and inserted.
- R4: `outstanding` equals the total number of valid entries in both tables. It rises by one per issued request and falls by one per retired entry.
- R5: A request is illegal, is answered with code 3 and is not inserted if either of these holds:
  - its kind is above 8;
  - its byte offset within the line plus `req_len` exceeds LINE_BYTES.
  A request that exactly fills to the line end is legal.
- R6: An issued request is forwarded with its line address and with `fwd_coh` set as follows:
  - kind 0 gives 0 (load);
  - kind 1 gives 1 (fetch);
  - kinds 5 and 6 give 3 (atomic);
  - every other write-class kind gives 2 (exclusive).
  `fwd_priv` is 1 only for access mode 1 (supervisor). Modes 0 (user) and 2 (device) both forward as 0.
- R7: A completion that hits raises `done_valid` one cycle later, together with the line and the latency. The latency is the completion cycle minus the acceptance cycle. `done_lat_valid` is set only when the latency is non-zero.
- R8: A completion whose line is absent from the selected table pulses `cpl_miss` for one cycle and leaves the count unchanged.
- R9: `deadlock` sets once any live entry's age reaches DEADLOCK_CYC cycles. It stays set until reset.
- R10: Each aliased request increments exactly one stall counter, and each counter saturates at its maximum:
  - on a write-table hit, kinds 0, 1 and 3 count in `stall_ld_behind_st` and all other kinds in `stall_st_behind_st`;
  - on a read-table hit only, kinds 2 and 4 count in `stall_st_behind_ld` and all other kinds in `stall_ld_behind_ld`.
- R11: The response to a request appears exactly one cycle after it. The screen sees the tables as they were before that cycle, so a same-cycle completion of the aliased line still yields code 1.
- R12: After reset:
  - the tables are empty;
  - the count, the stall counters and all flags are zero;
  - no response or completion is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request present |
| req_kind | input | 4 | Request kind code (R1) |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | LEN_W | Access length in bytes |
| req_mode | input | 2 | Access mode: 0 user, 1 supervisor, 2 device |
| rsp_valid | output | 1 | Result for the previous cycle's request |
| rsp_code | output | 2 | 0 issued, 1 aliased, 2 full, 3 illegal |
| fwd_valid | output | 1 | Coherence request sent downstream |
| fwd_line | output | LINE_W | Line address of the forwarded request |
| fwd_coh | output | 2 | Coherence kind: 0 load, 1 fetch, 2 exclusive, 3 atomic |
| fwd_priv | output | 1 | Supervisor access flag |
| cpl_valid | input | 1 | Completion present |
| cpl_is_write | input | 1 | Completion targets the write table |
| cpl_line | input | LINE_W | Completed line address |
| done_valid | output | 1 | A completion retired an entry |
| done_is_write | output | 1 | Retired entry was write-class |
| done_line | output | LINE_W | Retired line address |
| done_latency | output | TIME_W | Cycles from acceptance to completion |
| done_lat_valid | output | 1 | Latency is non-zero |
| cpl_miss | output | 1 | Completion matched no entry |
| deadlock | output | 1 | Sticky age-threshold flag |
| outstanding | output | CNT_OUT_W | Live entry count |
| stall_ld_behind_st | output | CNT_W | Read-like requests blocked by the write table |
| stall_st_behind_st | output | CNT_W | Other requests blocked by the write table |
| stall_ld_behind_ld | output | CNT_W | Other requests blocked by the read table |
| stall_st_behind_ld | output | CNT_W | Stores blocked by the read table |

## Verification
The assertions check the following on every cycle:
- the outstanding count matches the summed occupancy of both tables and never passes the ceiling;
- no line is ever held twice in a table;
- an insert always finds a free slot;
- the deadlock flag never falls outside reset;
- a latency flag appears only with a retirement;
- the stall counters never decrease.

The bench scenarios show what a property cannot express directly:
- which table each kind lands in;
- the exact result codes for alias, capacity and span cases;
- the coherence translation per kind and mode;
- the measured latency;
- the same-cycle completion ordering;
- counter saturation;
- the cycle at which the watchdog trips.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

    typedef enum logic [3:0] {
        KIND_LOAD    = 4'd0,
        KIND_FETCH   = 4'd1,
        KIND_STORE   = 4'd2,
        KIND_RMW_RD  = 4'd3,
        KIND_RMW_WR  = 4'd4,
        KIND_LINK_LD = 4'd5,
        KIND_COND_ST = 4'd6,
        KIND_LOCK_RD = 4'd7,
        KIND_LOCK_WR = 4'd8
    } req_kind_e;

    typedef enum logic [1:0] {
        COH_LOAD   = 2'd0,
        COH_FETCH  = 2'd1,
        COH_EXCL   = 2'd2,
        COH_ATOMIC = 2'd3
    } coh_kind_e;

    typedef enum logic [1:0] {
        RSP_ISSUED  = 2'd0,
        RSP_ALIASED = 2'd1,
        RSP_FULL    = 2'd2,
        RSP_ILLEGAL = 2'd3
    } rsp_code_e;

    localparam logic [1:0] MODE_SUPER = 2'd1;

    // stall counter slots
    localparam int STALL_LD_ST = 0;
    localparam int STALL_ST_ST = 1;
    localparam int STALL_LD_LD = 2;
    localparam int STALL_ST_LD = 3;

    function automatic logic kind_known(input logic [3:0] k);
        return k <= 4'd8;
    endfunction

    function automatic logic kind_writes(input logic [3:0] k);
        return (k >= 4'd2) && (k <= 4'd8);
    endfunction

    // request counted as read-like when blocked by a write-class line
    function automatic logic kind_readlike(input logic [3:0] k);
        return (k == KIND_LOAD) || (k == KIND_FETCH) || (k == KIND_RMW_RD);
    endfunction

    // request counted as store-like when blocked by a read-class line
    function automatic logic kind_storelike(input logic [3:0] k);
        return (k == KIND_STORE) || (k == KIND_RMW_WR);
    endfunction

endpackage

// File: rtl/mrt_xlate.sv
module mrt_xlate
    import mrt_pkg::*;
(
    input  logic [3:0] kind,
    input  logic [1:0] mode,
    output logic [1:0] coh,
    output logic       priv
);

    always_comb begin
        unique case (kind)
            KIND_LOAD:                  coh = COH_LOAD;
            KIND_FETCH:                 coh = COH_FETCH;
            KIND_LINK_LD, KIND_COND_ST: coh = COH_ATOMIC;
            default:                    coh = COH_EXCL;
        endcase
        // device accesses travel as user accesses
        priv = (mode == MODE_SUPER);
    end

endmodule

// File: rtl/mrt_cam.sv
module mrt_cam #(
    parameter int          ENTRIES   = 4,
    parameter int          LINE_W    = 12,
    parameter int          TIME_W    = 16,
    parameter int unsigned AGE_LIMIT = 4096,
    parameter int          OCC_W     = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now,
    input  logic [LINE_W-1:0] look_line,
    output logic              look_hit,
    input  logic              ins_en,
    input  logic [LINE_W-1:0] ins_line,
    input  logic              rm_en,
    input  logic [LINE_W-1:0] rm_line,
    output logic              rm_hit,
    output logic [TIME_W-1:0] rm_stamp,
    output logic [OCC_W-1:0]  occ,
    output logic              aged
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][LINE_W-1:0] line;
        logic [ENTRIES-1:0][TIME_W-1:0] stamp;
    } cam_t;

    cam_t st_q, st_d;

    logic [ENTRIES-1:0] look_vec, rm_vec, old_vec;
    logic [IDX_W-1:0]   free_idx;
    logic               free_ok;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic [TIME_W-1:0] age;
        assign age         = now - st_q.stamp[g];
        assign look_vec[g] = st_q.vld[g] && (st_q.line[g] == look_line);
        assign rm_vec[g]   = st_q.vld[g] && (st_q.line[g] == rm_line);
        assign old_vec[g]  = st_q.vld[g] && (age >= TIME_W'(AGE_LIMIT));
    end

    always_comb begin
        st_d     = st_q;
        free_idx = '0;
        free_ok  = 1'b0;
        rm_stamp = '0;
        occ      = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rm_vec[i]) rm_stamp = rm_stamp | st_q.stamp[i];
            occ = occ + OCC_W'(st_q.vld[i]);
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!st_q.vld[i]) begin
                free_idx = IDX_W'(i);
                free_ok  = 1'b1;
            end
        end
        if (rm_en) st_d.vld = st_d.vld & ~rm_vec;
        if (ins_en && free_ok) begin
            st_d.vld[free_idx]   = 1'b1;
            st_d.line[free_idx]  = ins_line;
            st_d.stamp[free_idx] = now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign look_hit = |look_vec;
    assign rm_hit   = |rm_vec;
    assign aged     = |old_vec;

    assert_unique_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_vec) && $onehot0(rm_vec));

    assert_insert_has_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> free_ok);

    assert_occ_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(ENTRIES));

endmodule

// File: rtl/outstanding_tracker.sv
module outstanding_tracker
    import mrt_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int LINE_BYTES   = 16,
    parameter int MAX_OUT      = 4,
    parameter int TIME_W       = 16,
    parameter int DEADLOCK_CYC = 4096,
    parameter int CNT_W        = 16,
    localparam int OFF_W       = $clog2(LINE_BYTES),
    localparam int LINE_W      = ADDR_W - OFF_W,
    localparam int LEN_W       = OFF_W + 1,
    localparam int CNT_OUT_W   = $clog2(MAX_OUT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [3:0]           req_kind,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [1:0]           req_mode,
    output logic                 rsp_valid,
    output logic [1:0]           rsp_code,
    output logic                 fwd_valid,
    output logic [LINE_W-1:0]    fwd_line,
    output logic [1:0]           fwd_coh,
    output logic                 fwd_priv,
    input  logic                 cpl_valid,
    input  logic                 cpl_is_write,
    input  logic [LINE_W-1:0]    cpl_line,
    output logic                 done_valid,
    output logic                 done_is_write,
    output logic [LINE_W-1:0]    done_line,
    output logic [TIME_W-1:0]    done_latency,
    output logic                 done_lat_valid,
    output logic                 cpl_miss,
    output logic                 deadlock,
    output logic [CNT_OUT_W-1:0] outstanding,
    output logic [CNT_W-1:0]     stall_ld_behind_st,
    output logic [CNT_W-1:0]     stall_st_behind_st,
    output logic [CNT_W-1:0]     stall_ld_behind_ld,
    output logic [CNT_W-1:0]     stall_st_behind_ld
);

    localparam int SPAN_W = LEN_W + 1;

    typedef struct packed {
        logic                      rsp_vld;
        logic [1:0]                rsp_code;
        logic                      fwd_vld;
        logic [LINE_W-1:0]         fwd_line;
        logic [1:0]                fwd_coh;
        logic                      fwd_priv;
        logic                      done_vld;
        logic                      done_wr;
        logic [LINE_W-1:0]         done_line;
        logic [TIME_W-1:0]         done_lat;
        logic                      lat_vld;
        logic                      cpl_miss;
        logic                      deadlock;
        logic [TIME_W-1:0]         now;
        logic [CNT_OUT_W-1:0]      count;
        logic [3:0][CNT_W-1:0]     stall;
    } trk_t;

    trk_t trk_q, trk_d;

    // table 0 holds read-class lines, table 1 write-class lines
    logic [1:0]             tab_look_hit, tab_ins, tab_rm, tab_rm_hit, tab_aged;
    logic [1:0][TIME_W-1:0] tab_stamp;
    logic [1:0][CNT_OUT_W-1:0] tab_occ;

    logic [LINE_W-1:0] req_line;
    logic [OFF_W-1:0]  req_off;
    logic [SPAN_W-1:0] req_span;
    logic              req_wr, req_bad, accept, retire;
    logic [1:0]        code_c, xl_coh;
    logic              xl_priv;
    logic [TIME_W-1:0] hit_stamp;

    assign req_line = req_addr[ADDR_W-1:OFF_W];
    assign req_off  = req_addr[OFF_W-1:0];
    assign req_span = SPAN_W'(req_off) + SPAN_W'(req_len);
    assign req_wr   = kind_writes(req_kind);
    assign req_bad  = !kind_known(req_kind) || (req_span > SPAN_W'(LINE_BYTES));

    mrt_xlate u_xlate (
        .kind (req_kind),
        .mode (req_mode),
        .coh  (xl_coh),
        .priv (xl_priv)
    );

    for (genvar t = 0; t < 2; t++) begin : g_tab
        assign tab_ins[t] = accept && (req_wr == (t == 1));
        assign tab_rm[t]  = cpl_valid && (cpl_is_write == (t == 1));
        mrt_cam #(
            .ENTRIES   (MAX_OUT),
            .LINE_W    (LINE_W),
            .TIME_W    (TIME_W),
            .AGE_LIMIT (DEADLOCK_CYC),
            .OCC_W     (CNT_OUT_W)
        ) u_cam (
            .clk       (clk),
            .rst_n     (rst_n),
            .now       (trk_q.now),
            .look_line (req_line),
            .look_hit  (tab_look_hit[t]),
            .ins_en    (tab_ins[t]),
            .ins_line  (req_line),
            .rm_en     (tab_rm[t]),
            .rm_line   (cpl_line),
            .rm_hit    (tab_rm_hit[t]),
            .rm_stamp  (tab_stamp[t]),
            .occ       (tab_occ[t]),
            .aged      (tab_aged[t])
        );
    end

    always_comb begin
        if (req_bad)                               code_c = RSP_ILLEGAL;
        else if (|tab_look_hit)                    code_c = RSP_ALIASED;
        else if (trk_q.count >= CNT_OUT_W'(MAX_OUT)) code_c = RSP_FULL;
        else                                       code_c = RSP_ISSUED;

        accept    = req_valid && (code_c == RSP_ISSUED);
        retire    = cpl_valid && tab_rm_hit[cpl_is_write];
        hit_stamp = tab_stamp[cpl_is_write];

        trk_d           = trk_q;
        trk_d.now       = trk_q.now + 1'b1;
        trk_d.rsp_vld   = req_valid;
        trk_d.rsp_code  = req_valid ? code_c : 2'd0;
        trk_d.fwd_vld   = accept;
        trk_d.fwd_line  = accept ? req_line : '0;
        trk_d.fwd_coh   = accept ? xl_coh : 2'd0;
        trk_d.fwd_priv  = accept && xl_priv;
        trk_d.done_vld  = retire;
        trk_d.done_wr   = retire && cpl_is_write;
        trk_d.done_line = retire ? cpl_line : '0;
        trk_d.done_lat  = retire ? (trk_q.now - hit_stamp) : '0;
        trk_d.lat_vld   = retire && (trk_q.now != hit_stamp);
        trk_d.cpl_miss  = cpl_valid && !retire;
        trk_d.deadlock  = trk_q.deadlock || (|tab_aged);
        trk_d.count     = trk_q.count + CNT_OUT_W'(accept) - CNT_OUT_W'(retire);

        if (req_valid && (code_c == RSP_ALIASED)) begin
            if (tab_look_hit[1]) begin
                if (kind_readlike(req_kind)) begin
                    if (trk_q.stall[STALL_LD_ST] != '1)
                        trk_d.stall[STALL_LD_ST] = trk_q.stall[STALL_LD_ST] + 1'b1;
                end else if (trk_q.stall[STALL_ST_ST] != '1) begin
                    trk_d.stall[STALL_ST_ST] = trk_q.stall[STALL_ST_ST] + 1'b1;
                end
            end else begin
                if (kind_storelike(req_kind)) begin
                    if (trk_q.stall[STALL_ST_LD] != '1)
                        trk_d.stall[STALL_ST_LD] = trk_q.stall[STALL_ST_LD] + 1'b1;
                end else if (trk_q.stall[STALL_LD_LD] != '1) begin
                    trk_d.stall[STALL_LD_LD] = trk_q.stall[STALL_LD_LD] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign rsp_valid          = trk_q.rsp_vld;
    assign rsp_code           = trk_q.rsp_code;
    assign fwd_valid          = trk_q.fwd_vld;
    assign fwd_line           = trk_q.fwd_line;
    assign fwd_coh            = trk_q.fwd_coh;
    assign fwd_priv           = trk_q.fwd_priv;
    assign done_valid         = trk_q.done_vld;
    assign done_is_write      = trk_q.done_wr;
    assign done_line          = trk_q.done_line;
    assign done_latency       = trk_q.done_lat;
    assign done_lat_valid     = trk_q.lat_vld;
    assign cpl_miss           = trk_q.cpl_miss;
    assign deadlock           = trk_q.deadlock;
    assign outstanding        = trk_q.count;
    assign stall_ld_behind_st = trk_q.stall[STALL_LD_ST];
    assign stall_st_behind_st = trk_q.stall[STALL_ST_ST];
    assign stall_ld_behind_ld = trk_q.stall[STALL_LD_LD];
    assign stall_st_behind_ld = trk_q.stall[STALL_ST_LD];

    assert_count_matches_tables_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.count == tab_occ[0] + tab_occ[1]);

    assert_count_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.count <= CNT_OUT_W'(MAX_OUT));

    assert_deadlock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.deadlock |=> trk_q.deadlock);

    assert_lat_needs_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_lat_valid |-> done_valid);

    assert_miss_excludes_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpl_miss && done_valid));

    assert_stall_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stall_ld_behind_st >= $past(stall_ld_behind_st)) &&
                 (stall_st_behind_st >= $past(stall_st_behind_st)) &&
                 (stall_ld_behind_ld >= $past(stall_ld_behind_ld)) &&
                 (stall_st_behind_ld >= $past(stall_st_behind_ld)));

endmodule

// File: tb/outstanding_tracker_tb_top.sv
module outstanding_tracker_tb_top;

    localparam int ADDR_W = 16, LINE_BYTES = 16, MAX_OUT = 4, TIME_W = 16;
    localparam int DL = 200, CNT_W = 3;
    localparam int LINE_W = 12, LEN_W = 5, CO_W = 3;
    localparam int SAT = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [3:0] req_kind = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [1:0] req_mode = '0;
    logic cpl_valid = 1'b0, cpl_is_write = 1'b0;
    logic [LINE_W-1:0] cpl_line = '0;
    logic rsp_valid, fwd_valid, fwd_priv, done_valid, done_is_write;
    logic done_lat_valid, cpl_miss, deadlock;
    logic [1:0] rsp_code, fwd_coh;
    logic [LINE_W-1:0] fwd_line, done_line;
    logic [TIME_W-1:0] done_latency;
    logic [CO_W-1:0] outstanding;
    logic [CNT_W-1:0] s_ldst, s_stst, s_ldld, s_stld;

    outstanding_tracker #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_OUT(MAX_OUT),
        .TIME_W(TIME_W), .DEADLOCK_CYC(DL), .CNT_W(CNT_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_len(req_len), .req_mode(req_mode),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .fwd_valid(fwd_valid), .fwd_line(fwd_line), .fwd_coh(fwd_coh), .fwd_priv(fwd_priv),
        .cpl_valid(cpl_valid), .cpl_is_write(cpl_is_write), .cpl_line(cpl_line),
        .done_valid(done_valid), .done_is_write(done_is_write), .done_line(done_line),
        .done_latency(done_latency), .done_lat_valid(done_lat_valid),
        .cpl_miss(cpl_miss), .deadlock(deadlock), .outstanding(outstanding),
        .stall_ld_behind_st(s_ldst), .stall_st_behind_st(s_stst),
        .stall_ld_behind_ld(s_ldld), .stall_st_behind_ld(s_stld)
    );

    always #4 clk = ~clk;   // 125 MHz

    int cyc = 0;
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    int n_cmp = 0, n_bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model built from the requirements
    int rd_m[int];
    int wr_m[int];
    int m_cnt = 0;
    int e_st[4] = '{0, 0, 0, 0};   // ld_behind_st, st_behind_st, ld_behind_ld, st_behind_ld

    typedef struct {
        int    code;
        int    line;
        int    coh;
        int    priv;
        string tag;
    } exp_t;
    exp_t sbq[$];

    function automatic int exp_coh(input int k);
        if (k == 0) return 0;
        if (k == 1) return 1;
        if (k == 5 || k == 6) return 3;
        return 2;
    endfunction

    function automatic void bump(input int slot);
        if (e_st[slot] < SAT) e_st[slot]++;
    endfunction

    // monitor: pops the scoreboard as responses appear
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && rsp_valid) begin
            if (sbq.size() == 0) begin
                chk("R11 response without request", 1, 0);
            end else begin
                e = sbq.pop_front();
                chk({e.tag, " code"}, int'(rsp_code), e.code);
                chk({e.tag, " fwd_valid"}, int'(fwd_valid), (e.code == 0) ? 1 : 0);
                if (e.code == 0) begin
                    chk({e.tag, " fwd_line"}, int'(fwd_line), e.line);
                    chk({e.tag, " fwd_coh"}, int'(fwd_coh), e.coh);
                    chk({e.tag, " fwd_priv"}, int'(fwd_priv), e.priv);
                end
            end
        end
    end

    task automatic drive(input bit rv, input int kind, input int line, input int off,
                         input int len, input int mode, input bit cv, input bit cw,
                         input int cline, input string tag);
        exp_t e;
        int   code = 0;
        bit   hit = 0;
        int   lat = 0;
        bit   isw;
        @(negedge clk);
        if (rv) begin
            isw = (kind >= 2 && kind <= 8);
            if (kind > 8 || off + len > LINE_BYTES) code = 3;
            else if (wr_m.exists(line)) begin
                code = 1;
                bump((kind == 0 || kind == 1 || kind == 3) ? 0 : 1);
            end else if (rd_m.exists(line)) begin
                code = 1;
                bump((kind == 2 || kind == 4) ? 3 : 2);
            end else if (m_cnt >= MAX_OUT) code = 2;
            else code = 0;
            e.code = code; e.line = line; e.coh = exp_coh(kind);
            e.priv = (mode == 1) ? 1 : 0; e.tag = tag;
            sbq.push_back(e);
        end
        if (cv) begin
            hit = cw ? wr_m.exists(cline) : rd_m.exists(cline);
            if (hit) begin
                if (cw) begin lat = cyc - wr_m[cline]; wr_m.delete(cline); end
                else    begin lat = cyc - rd_m[cline]; rd_m.delete(cline); end
                m_cnt--;
            end
        end
        if (rv && code == 0) begin
            if (isw) wr_m[line] = cyc;
            else     rd_m[line] = cyc;
            m_cnt++;
        end
        req_valid    = rv;
        req_kind     = 4'(kind);
        req_addr     = ADDR_W'((line << 4) | off);
        req_len      = LEN_W'(len);
        req_mode     = 2'(mode);
        cpl_valid    = cv;
        cpl_is_write = cw;
        cpl_line     = LINE_W'(cline);
        @(negedge clk);
        req_valid = 1'b0;
        cpl_valid = 1'b0;
        if (cv) begin
            chk({tag, " done_valid"}, int'(done_valid), hit ? 1 : 0);
            chk({tag, " cpl_miss"}, int'(cpl_miss), hit ? 0 : 1);
            if (hit) begin
                chk({tag, " done_line"}, int'(done_line), cline);
                chk({tag, " done_is_write"}, int'(done_is_write), cw ? 1 : 0);
                chk({tag, " latency"}, int'(done_latency), lat);
                chk({tag, " lat_valid"}, int'(done_lat_valid), (lat != 0) ? 1 : 0);
            end
        end
        chk({tag, " R4 outstanding"}, int'(outstanding), m_cnt);
    endtask

    task automatic req(input int kind, input int line, input int off, input int len,
                       input int mode, input string tag);
        drive(1'b1, kind, line, off, len, mode, 1'b0, 1'b0, 0, tag);
    endtask

    task automatic cpl(input bit cw, input int line, input string tag);
        drive(1'b0, 0, 0, 0, 0, 0, 1'b1, cw, line, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        cpl_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_m.delete();
        wr_m.delete();
        sbq.delete();
        m_cnt = 0;
        e_st = '{0, 0, 0, 0};
    endtask

    task automatic chk_stalls(input string tag);
        chk({tag, " R10 ld_behind_st"}, int'(s_ldst), e_st[0]);
        chk({tag, " R10 st_behind_st"}, int'(s_stst), e_st[1]);
        chk({tag, " R10 ld_behind_ld"}, int'(s_ldld), e_st[2]);
        chk({tag, " R10 st_behind_ld"}, int'(s_stld), e_st[3]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R12 actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int s_f;
        do_reset();
        // R12 reset state
        chk("R12 rsp_valid", int'(rsp_valid), 0);
        chk("R12 fwd_valid", int'(fwd_valid), 0);
        chk("R12 done_valid", int'(done_valid), 0);
        chk("R12 outstanding", int'(outstanding), 0);
        chk("R12 deadlock", int'(deadlock), 0);
        chk_stalls("R12");

        // fill to the ceiling with varied kinds and modes (R1, R6, R11)
        req(0, 'h010, 0, 4, 0, "R6 R11 load A user");
        req(2, 'h020, 4, 8, 1, "R6 store B supervisor");
        req(5, 'h030, 0, 16, 2, "R6 linked load C device");
        req(1, 'h040, 0, 4, 0, "R6 fetch D");
        req(0, 'h050, 0, 4, 0, "R3 full E");

        // aliasing against both tables (R2, R10)
        req(0, 'h020, 0, 4, 0, "R2 load alias on B");
        req(2, 'h010, 0, 4, 0, "R2 store alias on A");
        req(1, 'h010, 8, 4, 0, "R2 fetch alias on A");
        chk_stalls("after aliases");

        // completion routing (R1, R8, R7)
        cpl(1'b1, 'h010, "R1 R8 write-table cpl of read line A");
        cpl(1'b0, 'h010, "R7 R1 complete A");

        // span and kind legality (R5)
        req(0, 'h060, 12, 5, 0, "R5 span past line end");
        req(9, 'h060, 0, 4, 0, "R5 undefined kind");
        req(0, 'h060, 12, 4, 0, "R5 exact fit");

        // same-cycle completion does not free the line for the screen (R11)
        drive(1'b1, 6, 'h020, 0, 4, 0, 1'b1, 1'b1, 'h020, "R11 R7 alias while B completes");

        cpl(1'b1, 'h030, "R1 linked load lives in write table");
        cpl(1'b0, 'h040, "R7 complete D");
        cpl(1'b0, 'h060, "R7 complete 60");

        // remaining translations (R6)
        req(3, 'h070, 0, 4, 0, "R6 rmw read");
        req(8, 'h071, 0, 4, 1, "R6 locked rmw write");
        req(7, 'h072, 0, 4, 2, "R6 locked rmw read");
        req(6, 'h073, 0, 4, 0, "R6 conditional store");
        req(4, 'h073, 0, 4, 0, "R2 rmw write alias");
        cpl(1'b1, 'h070, "R1 complete 70");
        cpl(1'b1, 'h071, "R1 complete 71");
        cpl(1'b1, 'h072, "R1 complete 72");
        cpl(1'b1, 'h073, "R1 complete 73");
        chk_stalls("after translations");

        // saturation (R10)
        req(2, 'h080, 0, 4, 0, "R10 store F");
        s_f = wr_m[128];
        for (int i = 0; i < 8; i++) req(0, 'h080, 0, 4, 0, "R10 saturate");
        chk_stalls("saturated");
        chk("R10 saturated value", int'(s_ldst), SAT);

        // age watchdog (R9)
        while (cyc < s_f + DL - 1) @(negedge clk);
        chk("R9 deadlock before threshold", int'(deadlock), 0);
        while (cyc < s_f + DL + 3) @(negedge clk);
        chk("R9 deadlock after threshold", int'(deadlock), 1);
        repeat (5) @(negedge clk);
        chk("R9 deadlock stays set", int'(deadlock), 1);
        chk("R11 scoreboard drained", sbq.size(), 0);

        do_reset();
        chk("R9 R12 deadlock cleared by reset", int'(deadlock), 0);
        chk("R12 outstanding after reset", int'(outstanding), 0);
        chk_stalls("R12 after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule